// File: doc/BRIEF.md
# Completion Event Interrupt Controller

This block turns the completion of a queued wait operation into one interrupt message. A wait that asks for an interrupt sets a sticky completion flag. If that flag was clear beforehand, the completion also raises a pending bit. While the pending bit is set, the block offers a message on a valid/ready output. The message carries the contents of a programmed data register and a programmed address register.

Two things can hold the message back: a software mask bit, and a transient busy input from the message fabric. The pending bit is cleared in either of two ways: the message is accepted, or software clears the completion flag. In the second case no message is sent.

Software reaches four 32-bit registers through a single-cycle write port and a combinational read port, selected by a word index:

| Index | Register | Contents |
|---|---|---|
| 0 | status | bit 0 is the completion flag |
| 1 | control | bit 31 is the mask, bit 30 is the pending bit |
| 2 | data | message data |
| 3 | address | message address |

Top module: `cie_ctrl`

## Requirements
- R1: After reset, control reads 0x80000000 (mask set, pending clear), and status, data and address all read 0. No message is valid.
- R2: Control bits 29..0 always read 0 and ignore writes. Control bit 30 (pending) cannot be changed by a write. Control bit 31 (mask) follows the written value.
- R3: A completion pulse with the interrupt qualifier high sets status bit 0. If that bit was clear, the pulse sets pending at the same edge. A pulse with the qualifier low changes nothing.
- R4: A qualified completion that arrives while status bit 0 is already set leaves pending unchanged.
- R5: While mask is 1, msg_valid stays low and pending stays set.
- R6: While msg_busy is high, msg_valid stays low and pending stays set. The message is offered once busy falls and mask is 0.
- R7: msg_valid equals pending AND NOT mask AND NOT busy. A cycle with msg_valid and msg_ready both high clears pending at that edge.
- R8: Writing 1 to status bit 0 clears the flag and clears pending, and no message is sent. If a qualified completion arrives in the same cycle, the completion wins: the flag stays set and pending is set.
- R9: msg_data equals the data register. msg_addr equals the address register, whose bits 1..0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_idx |
| wait_done | input | 1 | Completion pulse of a wait operation |
| wait_irq | input | 1 | Completion requests an interrupt |
| msg_busy | input | 1 | Transient busy, holds the message |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with valid |
| msg_data | output | 32 | Message data |
| msg_addr | output | 32 | Message address |

## Verification
The hardest case to reach is a qualified completion that arrives while the completion flag is still set but pending has already been retired. To get there, the stimulus first raises a completion and lets its message drain through an unmasked, idle, ready output. Only then does it apply a second completion, with every combination of mask, busy and ready. The same sweep covers the fresh-flag case, so every hold and release path is seen from both starting states.

// File: rtl/cie_pkg.sv
package cie_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned IDX_W = 2;
  localparam int unsigned MASK_BIT = 31;
  localparam int unsigned PEND_BIT = 30;

  typedef enum logic [IDX_W-1:0] {
    IDX_STAT = 2'd0,
    IDX_CTRL = 2'd1,
    IDX_DATA = 2'd2,
    IDX_ADDR = 2'd3
  } reg_idx_e;

  // Control word image: only the mask and pending bits are ever non-zero.
  function automatic logic [DW-1:0] ctrl_word(input logic mask, input logic pend);
    logic [DW-1:0] w;
    w = '0;
    w[MASK_BIT] = mask;
    w[PEND_BIT] = pend;
    return w;
  endfunction

  // Message address is word aligned.
  function automatic logic [DW-1:0] word_align(input logic [DW-1:0] a);
    return {a[DW-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/cie_flag.sv
module cie_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_done,
  input  logic wait_irq,
  input  logic sw_clr,
  output logic flag,
  output logic evt
);
  logic qual;
  logic flag_eff;

  assign qual     = wait_done & wait_irq;
  // A software clear is applied before a completion in the same cycle.
  assign flag_eff = flag & ~sw_clr;
  assign evt      = qual & ~flag_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (qual) flag <= 1'b1;
    else if (sw_clr) flag <= 1'b0;
  end

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> flag);
  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !qual) |=> !flag);
endmodule

// File: rtl/cie_pend.sv
module cie_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic sw_clr,
  input  logic mask,
  input  logic busy,
  input  logic ready,
  output logic pend,
  output logic valid,
  output logic sent
);
  assign valid = pend & ~mask & ~busy;
  assign sent  = valid & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pend <= 1'b0;
    else if (evt)             pend <= 1'b1;
    else if (sent || sw_clr)  pend <= 1'b0;
  end

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !valid);
  // R7
  send_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sent && !evt) |=> !pend);
  // R3
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && busy && !sw_clr) |=> pend);
  // R8
  sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !evt) |=> !pend);
endmodule

// File: rtl/cie_ctrl.sv
module cie_ctrl
  import cie_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            wait_done,
  input  logic            wait_irq,
  input  logic            msg_busy,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [DW-1:0]   msg_data,
  output logic [DW-1:0]   msg_addr
);
  logic          mask_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] addr_q;
  logic          flag;
  logic          evt;
  logic          pend;
  logic          sent;
  logic          sw_clr;

  assign sw_clr = reg_wr && (reg_idx == IDX_STAT) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b1;
      data_q <= '0;
      addr_q <= '0;
    end else if (reg_wr) begin
      case (reg_idx)
        IDX_CTRL: mask_q <= reg_wdata[MASK_BIT];
        IDX_DATA: data_q <= reg_wdata;
        IDX_ADDR: addr_q <= word_align(reg_wdata);
        default:  ;
      endcase
    end
  end

  cie_flag u_flag (
    .clk(clk), .rst_n(rst_n), .wait_done(wait_done), .wait_irq(wait_irq),
    .sw_clr(sw_clr), .flag(flag), .evt(evt)
  );

  cie_pend u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sw_clr(sw_clr), .mask(mask_q),
    .busy(msg_busy), .ready(msg_ready), .pend(pend), .valid(msg_valid),
    .sent(sent)
  );

  always_comb begin
    case (reg_idx)
      IDX_STAT: reg_rdata = {{(DW-1){1'b0}}, flag};
      IDX_CTRL: reg_rdata = ctrl_word(mask_q, pend);
      IDX_DATA: reg_rdata = data_q;
      default:  reg_rdata = addr_q;
    endcase
  end

  assign msg_data = data_q;
  assign msg_addr = addr_q;

  // R4
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_done && wait_irq && flag && !sw_clr && !sent) |=> pend == $past(pend));
  // R7
  valid_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (pend && flag));
  // R9
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_addr[1:0] == 2'b00);
endmodule

// File: tb/cie_ctrl_test.sv
module cie_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_idx = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic wait_done = 0, wait_irq = 0, msg_busy = 0, msg_ready = 0, msg_valid;
  logic [31:0] msg_data, msg_addr;
  int checks = 0, fails = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  cie_ctrl uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wait_done(wait_done),
    .wait_irq(wait_irq), .msg_busy(msg_busy), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_data(msg_data), .msg_addr(msg_addr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(input logic [1:0] i, input logic [31:0] d);
    reg_wr = 1; reg_idx = i; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] i, output logic [31:0] d);
    reg_idx = i; #0.5; d = reg_rdata;
  endtask

  task automatic pulse(input logic q);
    wait_done = 1; wait_irq = q; tick(); wait_done = 0; wait_irq = 0;
  endtask

  function automatic logic [31:0] cw(input logic m, input logic p);
    return (32'(m) << 31) | (32'(p) << 30);
  endfunction

  initial begin
    #100000;
    if (!done_flag) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    // R1 reset state
    rd(1, v); chk("R1 ctrl", v, 32'h8000_0000);
    rd(0, v); chk("R1 stat", v, 0);
    rd(2, v); chk("R1 data", v, 0);
    rd(3, v); chk("R1 addr", v, 0);
    chk("R1 valid", msg_valid, 0);
    // R2 reserved bits and read-only pending
    wr(1, 32'hFFFF_FFFF); rd(1, v); chk("R2 all ones", v, cw(1, 0));
    wr(1, 32'h7FFF_FFFF); rd(1, v); chk("R2 mask clear", v, cw(0, 0));
    wr(1, 32'h8000_0000);
    // R9 message fields
    wr(2, 32'hA5C3_1E77); wr(3, 32'h1234_567F);
    chk("R9 data", msg_data, 32'hA5C3_1E77);
    chk("R9 addr", msg_addr, 32'h1234_567C);
    rd(3, v); chk("R9 addr read", v, 32'h1234_567C);
    // R3 no qualifier: nothing changes
    pulse(0); rd(0, v); chk("R3 unqualified stat", v, 0);
    rd(1, v); chk("R3 unqualified pend", v, cw(1, 0));
    // R8 clear of status retires pending, no message
    pulse(1); rd(1, v); chk("R3 pend set", v, cw(1, 1));
    wr(0, 1); rd(1, v); chk("R8 pend cleared", v, cw(1, 0));
    rd(0, v); chk("R8 flag cleared", v, 0);
    wr(1, 0); chk("R8 no message", msg_valid, 0);
    wr(1, cw(1, 0));
    // R8 clear and completion in the same cycle: completion wins
    reg_wr = 1; reg_idx = 0; reg_wdata = 1; wait_done = 1; wait_irq = 1;
    tick(); reg_wr = 0; wait_done = 0; wait_irq = 0;
    rd(0, v); chk("R8 same-cycle flag", v, 1);
    rd(1, v); chk("R8 same-cycle pend", v, cw(1, 1));
    // Sweep mask, busy, ready and prior flag state
    for (int k = 0; k < 16; k++) begin
      logic m, b, r, pre, ep, ev;
      m = k[0]; b = k[1]; r = k[2]; pre = k[3];
      msg_busy = 0; msg_ready = 0;
      wr(1, cw(1, 0)); wr(0, 1);
      if (pre) begin
        pulse(1); wr(1, 0); msg_ready = 1; tick(); msg_ready = 0;
        rd(1, v); chk("R7 drained before sweep", v, cw(0, 0));
      end
      wr(1, cw(m, 0)); msg_busy = b; msg_ready = r;
      pulse(1);
      ep = !pre; ev = ep && !m && !b;
      rd(1, v); chk(pre ? "R4 pend unchanged" : "R3 pend raised", v, cw(m, ep));
      chk(m ? "R5 masked valid" : (b ? "R6 busy valid" : "R7 valid"), msg_valid, ev);
      tick();
      rd(1, v); chk(r ? "R7 handshake" : "R5 R6 held", v, cw(m, ep && !(ev && r)));
      msg_busy = 0; msg_ready = 1;
      wr(1, 0); tick();
      rd(1, v); chk("R6 released", v, cw(0, 0));
      rd(0, v); chk("R3 flag kept", v, 1);
      msg_ready = 0;
    end
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule